// File: doc/BRIEF.md
# Cascaded Mappable Interrupt Controller

This block gathers interrupt sources into two 8-bit local groups and one 8-bit mappable group. Every source line first passes a two-flop synchronizer. Software programs a mask for each local group. It also programs two independent masks over the same mappable status byte. The OR of mappable status and map mask 0 appears in local group 0 at bit 7. The OR of mappable status and map mask 1 appears in local group 1 at bit 3. This makes a two-level cascade. The external source line at each of those two positions is not used.

Each local group drives one processor interrupt request. The request is the OR of that group's status bits qualified by its mask, and it includes the cascade bit. The registers are read and written one byte at a time over a simple synchronous bus. Reads are combinational, and writes take effect at the clock edge. A separate 16-bit active-low status view shows local group 1 in its upper byte and local group 0 in its lower byte. A legacy mask qualifies the lower byte.

Software numbers the sources as follows: 0 to 7 for local group 0, 8 to 15 for local group 1, 16 to 23 for map mask 0 bits and 24 to 31 for map mask 1 bits.

Top module: `casc_irq_ctrl`

## Requirements
- R1: After reset all five mask registers read 0x00 and both `irq_o` bits are 0.
- R2: Local status 0 (address 0x0) reads the synchronized `lcl0_src_i` on bits 6..0.
- R3: Local status 1 (address 0x2) reads the synchronized `lcl1_src_i` on bits 7..4 and 2..0.
- R4: Mappable status (address 0x8) reads the synchronized `map_src_i`.
- R5: Local status 0 bit 7 equals the OR of mappable status AND map mask 0, and `lcl0_src_i[7]` has no effect.
- R6: Local status 1 bit 3 equals the OR of mappable status AND map mask 1, and `lcl1_src_i[3]` has no effect.
- R7: `irq_o[n]` is 1 exactly when local status n AND local mask n is non-zero. The local masks are at 0x1 for group 0 and 0x3 for group 1.
- R8: Mask registers read back the last byte written to them: local mask 0 at 0x1, local mask 1 at 0x3, map mask 0 at 0x9, legacy mask at 0xC and map mask 1 at 0xD (four above map mask 0). A write to one mask leaves the other masks unchanged.
- R9: Writes to the status addresses 0x0, 0x2, 0x8, 0xE and 0xF change no register and no status.
- R10: `legacy_n_o[15:8]` is the complement of local status 1. `legacy_n_o[7:0]` is the complement of (local status 0 AND legacy mask). The same halves read back at 0xF and 0xE.
- R11: Reads of the unassigned addresses 0x4 to 0x7, 0xA and 0xB return 0x00, and writes to them change no register.
- R12: A change on a source input is visible in status after exactly two rising clock edges: it is not visible after one edge and it is visible after two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lcl0_src_i | input | 8 | Local group 0 source levels (bit 7 unused) |
| lcl1_src_i | input | 8 | Local group 1 source levels (bit 3 unused) |
| map_src_i | input | 8 | Mappable source levels |
| bus_sel_i | input | 1 | Bus access select |
| bus_we_i | input | 1 | Write enable (1 = write, 0 = read) |
| bus_addr_i | input | 4 | Byte register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, 0 when no read is selected |
| irq_o | output | 2 | Request for local group 1 (bit 1) and local group 0 (bit 0) |
| legacy_n_o | output | 16 | Active-low status view |

## Verification
The hardest case to reach from the ports is a request that arises only through the cascade. For that case a mappable source must be enabled in the matching map mask and the cascade bit must be enabled in the local mask, while the direct source at that bit position is driven to the opposite value. The bench sweeps all 256 mappable patterns against rotating map-mask and local-mask values. It drives the two unused direct inputs high and low along the way, so the cascade and direct paths are separated from each other. A separate sequence checks the status one edge and two edges after an input change to pin down the synchronizer depth.

// File: rtl/cic_pkg.sv
package cic_pkg;
  localparam int unsigned GRP_W  = 8;
  localparam int unsigned ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_L0_STAT   = 4'h0,
    A_L0_MASK   = 4'h1,
    A_L1_STAT   = 4'h2,
    A_L1_MASK   = 4'h3,
    A_MAP_STAT  = 4'h8,
    A_MAP_MASK0 = 4'h9,
    A_LEG_MASK  = 4'hC,
    A_MAP_MASK1 = 4'hD,
    A_LEG_LO    = 4'hE,
    A_LEG_HI    = 4'hF
  } reg_addr_e;

  typedef struct packed {
    logic [GRP_W-1:0] l0;
    logic [GRP_W-1:0] l1;
    logic [GRP_W-1:0] mm0;
    logic [GRP_W-1:0] mm1;
    logic [GRP_W-1:0] leg;
  } mask_set_t;
endpackage

// File: rtl/cic_sync.sv
module cic_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[0] <= '0;
        else         stage_q[0] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/cic_regs.sv
module cic_regs
  import cic_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [GRP_W-1:0]  wdata_i,
  output mask_set_t         masks_o
);
  mask_set_t masks_q;

  // read-only and unassigned addresses fall to default: no state change
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      masks_q <= '0;
    end else if (wr_en_i) begin
      case (addr_i)
        A_L0_MASK:   masks_q.l0  <= wdata_i;
        A_L1_MASK:   masks_q.l1  <= wdata_i;
        A_MAP_MASK0: masks_q.mm0 <= wdata_i;
        A_MAP_MASK1: masks_q.mm1 <= wdata_i;
        A_LEG_MASK:  masks_q.leg <= wdata_i;
        default:     masks_q     <= masks_q;
      endcase
    end
  end

  assign masks_o = masks_q;
endmodule

// File: rtl/cic_cascade.sv
module cic_cascade
  import cic_pkg::*;
#(
  parameter int unsigned CASC0_BIT = 7,
  parameter int unsigned CASC1_BIT = 3
) (
  input  logic [GRP_W-1:0]   l0_sync_i,
  input  logic [GRP_W-1:0]   l1_sync_i,
  input  logic [GRP_W-1:0]   map_sync_i,
  input  mask_set_t          masks_i,
  output logic [GRP_W-1:0]   stat0_o,
  output logic [GRP_W-1:0]   stat1_o,
  output logic [1:0]         irq_o,
  output logic [2*GRP_W-1:0] legacy_n_o
);
  logic casc0, casc1;

  assign casc0 = |(map_sync_i & masks_i.mm0);
  assign casc1 = |(map_sync_i & masks_i.mm1);

  for (genvar i = 0; i < GRP_W; i++) begin : g_bit
    if (i == CASC0_BIT) begin : g_c0
      assign stat0_o[i] = casc0;
    end else begin : g_d0
      assign stat0_o[i] = l0_sync_i[i];
    end
    if (i == CASC1_BIT) begin : g_c1
      assign stat1_o[i] = casc1;
    end else begin : g_d1
      assign stat1_o[i] = l1_sync_i[i];
    end
  end

  assign irq_o[0]   = |(stat0_o & masks_i.l0);
  assign irq_o[1]   = |(stat1_o & masks_i.l1);
  assign legacy_n_o = ~{stat1_o, stat0_o & masks_i.leg};
endmodule

// File: rtl/cic_rdmux.sv
module cic_rdmux
  import cic_pkg::*;
(
  input  logic               rd_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [GRP_W-1:0]   stat0_i,
  input  logic [GRP_W-1:0]   stat1_i,
  input  logic [GRP_W-1:0]   map_stat_i,
  input  mask_set_t          masks_i,
  input  logic [2*GRP_W-1:0] legacy_n_i,
  output logic [GRP_W-1:0]   rdata_o
);
  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      case (addr_i)
        A_L0_STAT:   rdata_o = stat0_i;
        A_L0_MASK:   rdata_o = masks_i.l0;
        A_L1_STAT:   rdata_o = stat1_i;
        A_L1_MASK:   rdata_o = masks_i.l1;
        A_MAP_STAT:  rdata_o = map_stat_i;
        A_MAP_MASK0: rdata_o = masks_i.mm0;
        A_MAP_MASK1: rdata_o = masks_i.mm1;
        A_LEG_MASK:  rdata_o = masks_i.leg;
        A_LEG_LO:    rdata_o = legacy_n_i[GRP_W-1:0];
        A_LEG_HI:    rdata_o = legacy_n_i[2*GRP_W-1:GRP_W];
        default:     rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/casc_irq_ctrl.sv
module casc_irq_ctrl
  import cic_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CASC0_BIT   = 7,
  parameter int unsigned CASC1_BIT   = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [GRP_W-1:0]   lcl0_src_i,
  input  logic [GRP_W-1:0]   lcl1_src_i,
  input  logic [GRP_W-1:0]   map_src_i,
  input  logic               bus_sel_i,
  input  logic               bus_we_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [GRP_W-1:0]   bus_wdata_i,
  output logic [GRP_W-1:0]   bus_rdata_o,
  output logic [1:0]         irq_o,
  output logic [2*GRP_W-1:0] legacy_n_o
);
  localparam int unsigned SRC_W = 3 * GRP_W;

  logic [SRC_W-1:0] src_sync;
  logic [GRP_W-1:0] l0_sync, l1_sync, map_stat;
  logic [GRP_W-1:0] stat0, stat1;
  mask_set_t        masks;

  cic_sync #(.W(SRC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({map_src_i, lcl1_src_i, lcl0_src_i}),
    .q_o    (src_sync)
  );

  assign {map_stat, l1_sync, l0_sync} = src_sync;

  cic_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (bus_sel_i & bus_we_i),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i),
    .masks_o (masks)
  );

  cic_cascade #(.CASC0_BIT(CASC0_BIT), .CASC1_BIT(CASC1_BIT)) u_casc (
    .l0_sync_i  (l0_sync),
    .l1_sync_i  (l1_sync),
    .map_sync_i (map_stat),
    .masks_i    (masks),
    .stat0_o    (stat0),
    .stat1_o    (stat1),
    .irq_o      (irq_o),
    .legacy_n_o (legacy_n_o)
  );

  cic_rdmux u_rdmux (
    .rd_en_i    (bus_sel_i & ~bus_we_i),
    .addr_i     (bus_addr_i),
    .stat0_i    (stat0),
    .stat1_i    (stat1),
    .map_stat_i (map_stat),
    .masks_i    (masks),
    .legacy_n_i (legacy_n_o),
    .rdata_o    (bus_rdata_o)
  );
endmodule

// File: rtl/cic_chk.sv
module cic_chk
  import cic_pkg::*;
#(
  parameter int unsigned CASC0_BIT = 7,
  parameter int unsigned CASC1_BIT = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               bus_sel_i,
  input logic               bus_we_i,
  input logic [ADDR_W-1:0]  bus_addr_i,
  input logic [GRP_W-1:0]   bus_wdata_i,
  input logic [1:0]         irq_o,
  input logic [2*GRP_W-1:0] legacy_n_o,
  input logic [GRP_W-1:0]   stat0,
  input logic [GRP_W-1:0]   stat1,
  input logic [GRP_W-1:0]   map_stat,
  input mask_set_t          masks
);
  logic ro_wr;
  assign ro_wr = bus_sel_i && bus_we_i &&
                 (bus_addr_i == A_L0_STAT || bus_addr_i == A_L1_STAT ||
                  bus_addr_i == A_MAP_STAT || bus_addr_i == A_LEG_LO ||
                  bus_addr_i == A_LEG_HI);

  a_r1_irq_quiet_in_reset: assert property (@(posedge clk_i)
    !rst_ni |-> irq_o == 2'b00);

  a_r7_irq0_needs_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o[0] |-> masks.l0 != '0);

  a_r7_irq1_needs_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o[1] |-> masks.l1 != '0);

  a_r5_casc0_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    masks.mm0 == '0 |-> !stat0[CASC0_BIT]);

  a_r6_casc1_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    masks.mm1 == '0 |-> !stat1[CASC1_BIT]);

  a_r4_idle_map_no_cascade: assert property (@(posedge clk_i) disable iff (!rst_ni)
    map_stat == '0 |-> !stat0[CASC0_BIT] && !stat1[CASC1_BIT]);

  a_r9_ro_write_keeps_masks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ro_wr |=> $stable(masks));

  a_r8_map_mask1_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_sel_i && bus_we_i && bus_addr_i == A_MAP_MASK1)
      |=> masks.mm1 == $past(bus_wdata_i) && $stable(masks.mm0));

  a_r10_legacy_lo_unqualified: assert property (@(posedge clk_i) disable iff (!rst_ni)
    masks.leg == '0 |-> legacy_n_o[GRP_W-1:0] == '1);
endmodule

bind casc_irq_ctrl cic_chk #(.CASC0_BIT(CASC0_BIT), .CASC1_BIT(CASC1_BIT)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_sel_i   (bus_sel_i),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .irq_o       (irq_o),
  .legacy_n_o  (legacy_n_o),
  .stat0       (stat0),
  .stat1       (stat1),
  .map_stat    (map_stat),
  .masks       (masks)
);

// File: tb/test_casc_irq_ctrl.sv
`timescale 1ns/1ps
module test_casc_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  src0 = '0, src1 = '0, msrc = '0;
  logic        sel = 1'b0, we = 1'b0;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [1:0]  irq;
  logic [15:0] leg_n;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  casc_irq_ctrl i_casc_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .lcl0_src_i(src0), .lcl1_src_i(src1), .map_src_i(msrc),
    .bus_sel_i(sel), .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq_o(irq), .legacy_n_o(leg_n)
  );

  // bench-side copies of programmed masks
  logic [7:0] m_l0 = 0, m_l1 = 0, m_mm0 = 0, m_mm1 = 0, m_leg = 0;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    sel = 1; we = 1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    sel = 0; we = 0;
    case (a)
      4'h1: m_l0 = d;  4'h3: m_l1 = d;  4'h9: m_mm0 = d;
      4'hD: m_mm1 = d; 4'hC: m_leg = d; default: ;
    endcase
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    sel = 1; we = 0; addr = a;
    #1 d = rdata;
    sel = 0;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [7:0] e_st0();
    return {|(msrc & m_mm0), src0[6:0]};
  endfunction
  function automatic logic [7:0] e_st1();
    return {src1[7:4], |(msrc & m_mm1), src1[2:0]};
  endfunction

  task automatic check_all(input string ctx);
    logic [7:0] d;
    rd(4'h0, d); chk({ctx, " R2 R5 stat0"}, {8'h0, d}, {8'h0, e_st0()});
    rd(4'h2, d); chk({ctx, " R3 R6 stat1"}, {8'h0, d}, {8'h0, e_st1()});
    rd(4'h8, d); chk({ctx, " R4 map stat"}, {8'h0, d}, {8'h0, msrc});
    chk({ctx, " R7 irq"}, {14'h0, irq},
        {14'h0, |(e_st1() & m_l1), |(e_st0() & m_l0)});
    chk({ctx, " R10 legacy port"}, leg_n, ~{e_st1(), e_st0() & m_leg});
    rd(4'hE, d); chk({ctx, " R10 legacy lo"}, {8'h0, d}, {8'h0, ~(e_st0() & m_leg)});
    rd(4'hF, d); chk({ctx, " R10 legacy hi"}, {8'h0, d}, {8'h0, ~e_st1()});
  endtask

  task automatic check_masks(input string ctx);
    logic [7:0] d;
    rd(4'h1, d); chk({ctx, " R8 l0 mask"}, {8'h0, d}, {8'h0, m_l0});
    rd(4'h3, d); chk({ctx, " R8 l1 mask"}, {8'h0, d}, {8'h0, m_l1});
    rd(4'h9, d); chk({ctx, " R8 map mask0"}, {8'h0, d}, {8'h0, m_mm0});
    rd(4'hD, d); chk({ctx, " R8 map mask1"}, {8'h0, d}, {8'h0, m_mm1});
    rd(4'hC, d); chk({ctx, " R8 legacy mask"}, {8'h0, d}, {8'h0, m_leg});
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 irq in reset", {14'h0, irq}, 16'h0);
    rst_n = 1;
    @(negedge clk);
    check_masks("R1 after reset");
    chk("R1 irq after reset", {14'h0, irq}, 16'h0);

    // R8: readback and independence, map mask 1 four above map mask 0
    wr(4'h9, 8'hA5); check_masks("R8 mm0");
    wr(4'hD, 8'h3C); check_masks("R8 mm1");
    wr(4'h1, 8'hF0); wr(4'h3, 8'h0F); wr(4'hC, 8'h99);
    check_masks("R8 all");

    // R9: writes to status addresses
    src0 = 8'h55; src1 = 8'hAA; msrc = 8'h81; settle();
    foreach (m_l0[i]) ;
    wr(4'h0, 8'hFF); wr(4'h2, 8'h00); wr(4'h8, 8'h7E); wr(4'hE, 8'h12); wr(4'hF, 8'h34);
    settle();
    check_masks("R9 ro write");
    check_all("R9 ro write");

    // R11: unassigned addresses
    for (int a = 4; a < 12; a++) begin
      if (a == 8 || a == 9) continue;
      wr(4'(a), 8'hFF);
      rd(4'(a), d);
      chk("R11 unassigned read", {8'h0, d}, 16'h0);
    end
    check_masks("R11 unassigned write");

    // sweep local group 0 (map idle -> cascade bit 0 even when src0[7]=1)
    msrc = 0; src1 = 0;
    for (int v = 0; v < 256; v++) begin
      src0 = 8'(v);
      wr(4'h1, 8'(v) ^ 8'h5A);
      wr(4'hC, 8'(v * 37 + 5));
      settle();
      check_all("L0 sweep R5 R7");
    end

    // sweep local group 1
    src0 = 0;
    for (int v = 0; v < 256; v++) begin
      src1 = 8'(v);
      wr(4'h3, ~8'(v * 3));
      settle();
      check_all("L1 sweep R6 R7");
    end

    // sweep mappable group with rotating masks, direct cascade inputs toggled
    for (int v = 0; v < 256; v++) begin
      msrc = 8'(v);
      src0 = (v % 2 == 0) ? 8'h80 : 8'h00;
      src1 = (v % 4 < 2) ? 8'h08 : 8'h00;
      wr(4'h9, 8'(v * 7 + 1));
      wr(4'hD, 8'(v * 13) ^ 8'hC3);
      wr(4'h1, (v % 3 == 0) ? 8'h00 : 8'h80);
      wr(4'h3, (v % 5 == 0) ? 8'h00 : 8'h08);
      settle();
      check_all("MAP sweep R4 R5 R6 R7");
    end

    // R12: synchronizer depth
    src0 = 0; src1 = 0; msrc = 0; settle();
    src0 = 8'h15;
    @(posedge clk); @(negedge clk);
    rd(4'h0, d); chk("R12 one edge", {8'h0, d}, 16'h0);
    @(posedge clk); @(negedge clk);
    rd(4'h0, d); chk("R12 two edges", {8'h0, d}, 16'h0015);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule